// File: doc/BRIEF.md
# SD card initialization clock burst generator

This block produces the short train of card clock pulses that an SD card needs after its supply comes up and before the first command. Software arms nothing directly. The block watches the slot's power state. When that state moves from ramping to fully on, one burst is allowed. Software then sets a start bit in the control register.

The block toggles the card clock pad on each tick of a slow clock enable that comes from an external divider. It counts completed pulses. After the programmed number of pulses it parks the pad low and clears the start bit by itself. In the same cycle it sets a sticky completion flag that software clears by writing one. The interrupt line is that flag gated by an enable bit.

The register port is a single-cycle write strobe with a combinational read. The burst length comes from an 8-bit field whose reset value is 74 pulses. At the slowest card clock of about 100 kHz, a 74-pulse burst ends within roughly 740 µs.

Top module: `sd_initclk_gen`

## Requirements
- R1: After synchronous reset, the control register (offset 0x100) reads 0x0000, the length register (offset 0x102) reads 0x4A00, the interrupt register (offset 0x10E) reads 0x0000, and `irq` and `card_clk` are 0.
- R2: A burst emits exactly the selected number of `card_clk` pulses, each a rise followed by a fall. `card_clk` is held low whenever no burst runs.
- R3: Control bit 6 reads 1 from the write that launches a burst until the edge on which the last pulse falls. On that same edge, interrupt register bit 2 (done) becomes 1.
- R4: Writing a 1 to interrupt register bit 2 clears done, and writing a 0 there leaves it set. If the final pulse and a clearing write fall on the same edge, the set wins.
- R5: `irq` is 1 exactly when done (bit 2) and the enable (bit 1 of the interrupt register, read/write) are both 1.
- R6: While a burst runs, writes of the start bit and writes to the length register are ignored. The pulse count stays unchanged and the length reads back its old value.
- R7: A start write launches a burst only if it is armed. Arming happens when `pwr_state` (00 off, 10 ramping, 11 on; 01 treated as off) moves from 10 to 11 on consecutive cycles. The arming is used up by one launch and lost when `pwr_state` leaves 11. A start write without arming has no effect.
- R8: The burst length is bits 15:8 of the length register, captured when the burst starts. A value of 0 selects the default of 74 pulses.
- R9: `card_clk` changes only on cycles where `clk_tick` is 1. A burst of N pulses takes exactly 2N ticks.
- R10: A synchronous reset during a burst stops it at once. It drives `card_clk` low, clears done and the arming, and restores the default length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| pwr_state | input | 2 | Slot power state: 00 off, 10 ramping, 11 on |
| clk_tick | input | 1 | Slow enable from the card clock divider, one tick per half period |
| card_clk | output | 1 | Card clock pad drive |
| irq | output | 1 | Completion interrupt |

## Verification
The cases hardest to reach from the ports are the ones where a write arrives at the wrong moment. Examples are a start or length write landing in the middle of a running burst, and a start write after an arming has already been used up. The bench reaches them by launching a burst and then injecting the writes a few cycles later. It then counts the rising edges on `card_clk` to prove the length did not move. Arming is driven through explicit power sequences: ramping then on, off then on, and on held steady. A stalled tick input freezes a burst halfway, so the bench can show that the pad does not move without a tick. Sweeping lengths 1 to 16 with a tick on every cycle pins the duration to exactly twice the length.

// File: rtl/sd_initclk_pkg.sv
package sd_initclk_pkg;

    localparam int REG_W      = 16;
    localparam int ADDR_W     = 12;
    localparam int CNT_W      = 8;
    localparam int DEF_PULSES = 74;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_LEN  = 12'h102;
    localparam logic [ADDR_W-1:0] OFS_IRQ  = 12'h10E;

    localparam int START_POS = 6;
    localparam int LEN_LSB   = 8;
    localparam int IEN_POS   = 1;
    localparam int DONE_POS  = 2;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_ALT  = 2'b01,
        PWR_RAMP = 2'b10,
        PWR_ON   = 2'b11
    } pwr_e;

    typedef struct packed {
        logic ien;
        logic done;
    } irq_state_t;

    function automatic logic [CNT_W-1:0] pick_len(input logic [CNT_W-1:0] field,
                                                  input logic [CNT_W-1:0] dflt);
        return (field == '0) ? dflt : field;
    endfunction

endpackage

// File: rtl/initclk_power_arm.sv
module initclk_power_arm
    import sd_initclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pwr_state,
    input  logic       consume,
    output logic       armed
);
    pwr_e prev_q;
    pwr_e cur;
    logic armed_q;

    assign cur = pwr_e'(pwr_state);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= PWR_OFF;
            armed_q <= 1'b0;
        end else begin
            prev_q <= cur;
            if (consume || cur != PWR_ON)
                armed_q <= 1'b0;
            else if (prev_q == PWR_RAMP)
                armed_q <= 1'b1;
        end
    end

    assign armed = armed_q;

    // R7: arming can only be held while the slot was on in the previous cycle
    p_arm_needs_on_r7: assert property (@(posedge clk) disable iff (rst)
        armed |-> $past(pwr_state) == PWR_ON);

endmodule

// File: rtl/initclk_regs.sv
module initclk_regs
    import sd_initclk_pkg::*;
#(
    parameter int                 AW       = ADDR_W,
    parameter int                 CW       = CNT_W,
    parameter logic [CNT_W-1:0]   LEN_RST  = CNT_W'(DEF_PULSES)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             busy,
    input  logic             armed,
    input  logic             done,
    output logic             launch,
    output logic [CW-1:0]    len_field,
    output irq_state_t       irq_st,
    output logic [REG_W-1:0] rdata
);
    logic       [CW-1:0] len_q;
    irq_state_t          st_q;
    logic                hit_ctrl, hit_len, hit_irq;
    logic                unused_wbits;

    assign hit_ctrl = wr && (addr == AW'(OFS_CTRL));
    assign hit_len  = wr && (addr == AW'(OFS_LEN));
    assign hit_irq  = wr && (addr == AW'(OFS_IRQ));

    assign launch = hit_ctrl && wdata[START_POS] && !busy && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= LEN_RST;
            st_q    <= '0;
        end else begin
            if (hit_len && !busy)
                len_q <= wdata[LEN_LSB +: CW];
            if (hit_irq)
                st_q.ien <= wdata[IEN_POS];
            if (done)
                st_q.done <= 1'b1;
            else if (hit_irq && wdata[DONE_POS])
                st_q.done <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_CTRL))
            rdata[START_POS] = busy;
        else if (addr == AW'(OFS_LEN))
            rdata[LEN_LSB +: CW] = len_q;
        else if (addr == AW'(OFS_IRQ)) begin
            rdata[IEN_POS]  = st_q.ien;
            rdata[DONE_POS] = st_q.done;
        end
    end

    assign len_field    = len_q;
    assign irq_st       = st_q;
    assign unused_wbits = ^{wdata[REG_W-1:0]};

    // R4: a set done flag survives unless a write-one clear arrives
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.done && !(hit_irq && wdata[DONE_POS])) |=> st_q.done);

    // R6: the length field cannot move while a burst runs
    p_len_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(len_q));

endmodule

// File: rtl/initclk_burst.sv
module initclk_burst
    import sd_initclk_pkg::*;
#(
    parameter int CW = CNT_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [CW-1:0] len_sel,
    input  logic          tick,
    output logic          busy,
    output logic          pad,
    output logic          done
);
    localparam int TW = CW + 2;

    logic          busy_q, pad_q;
    logic [CW-1:0] len_q, cnt_q;
    logic [TW-1:0] ticks_q;
    logic          last_pulse;

    assign last_pulse = (cnt_q == len_q - CW'(1));
    assign done       = busy_q && tick && pad_q && last_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            pad_q   <= 1'b0;
            len_q   <= '0;
            cnt_q   <= '0;
            ticks_q <= '0;
        end else if (launch) begin
            busy_q  <= 1'b1;
            pad_q   <= 1'b0;
            len_q   <= len_sel;
            cnt_q   <= '0;
            ticks_q <= '0;
        end else if (busy_q && tick) begin
            ticks_q <= ticks_q + TW'(1);
            if (!pad_q) begin
                pad_q <= 1'b1;
            end else begin
                pad_q <= 1'b0;
                cnt_q <= cnt_q + CW'(1);
                if (last_pulse)
                    busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign pad  = pad_q;

    // R2: pad parked low outside a burst
    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !pad_q);

    // R9: no tick, no pad movement
    p_pad_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pad_q));

    // R9: a burst never spends more than twice its length in ticks
    p_tick_budget_r9: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ticks_q <= {1'b0, len_q, 1'b0});

    // R8: captured length is never zero
    p_len_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> len_q != '0);

endmodule

// File: rtl/sd_initclk_gen.sv
module sd_initclk_gen
    import sd_initclk_pkg::*;
#(
    parameter int AW         = ADDR_W,
    parameter int CW         = CNT_W,
    parameter int PULSES_DEF = DEF_PULSES
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic [1:0]       pwr_state,
    input  logic             clk_tick,
    output logic             card_clk,
    output logic             irq
);
    localparam logic [CW-1:0] LEN_DEF = CW'(PULSES_DEF);

    logic          launch, armed, busy, done;
    logic [CW-1:0] len_field, len_eff;
    irq_state_t    irq_st;

    initclk_power_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .pwr_state (pwr_state),
        .consume   (launch),
        .armed     (armed)
    );

    initclk_regs #(.AW(AW), .CW(CW), .LEN_RST(LEN_DEF)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .armed     (armed),
        .done      (done),
        .launch    (launch),
        .len_field (len_field),
        .irq_st    (irq_st),
        .rdata     (reg_rdata)
    );

    assign len_eff = pick_len(len_field, LEN_DEF);

    initclk_burst #(.CW(CW)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .len_sel (len_eff),
        .tick    (clk_tick),
        .busy    (busy),
        .pad     (card_clk),
        .done    (done)
    );

    assign irq = irq_st.done && irq_st.ien;

    // R3: the end of a burst always leaves the done flag set
    p_end_sets_done_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> irq_st.done);

    // R7: a launch consumes the arming
    p_launch_consumes_r7: assert property (@(posedge clk) disable iff (rst)
        launch |=> !armed);

endmodule

// File: tb/sd_initclk_gen_bench.sv
module sd_initclk_gen_bench;
    localparam int PERIOD = 10;
    localparam logic [11:0] A_CTRL = 12'h100;
    localparam logic [11:0] A_LEN  = 12'h102;
    localparam logic [11:0] A_IRQ  = 12'h10E;

    logic        clk = 0, rst = 1, reg_wr = 0, clk_tick = 0;
    logic [11:0] reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic [1:0]  pwr_state = 2'b00;
    logic        card_clk, irq;

    int checks = 0, fails = 0, rises = 0, tick_per = 1;
    logic prev_pad = 0;

    sd_initclk_gen u_sd_initclk_gen (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_state(pwr_state),
        .clk_tick(clk_tick), .card_clk(card_clk), .irq(irq));

    always #(PERIOD/2) clk = ~clk;

    initial begin : tick_gen
        int ph = 0;
        forever begin
            @(negedge clk);
            if (tick_per == 0) clk_tick = 0;
            else if (tick_per == 1) clk_tick = 1;
            else begin
                clk_tick = (ph == 0);
                ph = (ph + 1) % tick_per;
            end
        end
    end

    initial begin : pad_mon
        forever begin
            @(negedge clk);
            if (card_clk && !prev_pad) rises++;
            prev_pad = card_clk;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm();
        @(negedge clk); pwr_state = 2'b10;
        @(negedge clk); pwr_state = 2'b11;
        @(negedge clk);
    endtask

    task automatic wait_done(output int cyc);
        int v;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            rd_reg(A_CTRL, v);
        end while (v[6] && cyc < 100000);
    endtask

    int v, cyc, r0;

    initial begin
        idle(3);
        rst = 0;
        // R1 reset state
        rd_reg(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd_reg(A_LEN, v);  chk("R1 len", v, 16'h4A00);
        rd_reg(A_IRQ, v);  chk("R1 irq reg", v, 0);
        chk("R1 irq pin", int'(irq), 0);
        chk("R1 card_clk", int'(card_clk), 0);

        // R7 start without arming
        pwr_state = 2'b11;
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040); idle(5);
        rd_reg(A_CTRL, v); chk("R7 unarmed start", v, 0);
        chk("R7 unarmed pulses", rises - r0, 0);

        // R2/R3 default burst
        pwr_state = 2'b00; idle(1);
        arm();
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040);
        rd_reg(A_CTRL, v); chk("R3 busy reads 1", v, 16'h0040);
        wait_done(cyc);
        chk("R2 default pulses", rises - r0, 74);
        chk("R9 default ticks", cyc, 148);
        rd_reg(A_IRQ, v); chk("R3 done set", v, 16'h0004);
        chk("R5 irq masked", int'(irq), 0);
        chk("R2 pad parked", int'(card_clk), 0);

        // R4/R5 W1C and gating
        wr_reg(A_IRQ, 16'h0002);
        rd_reg(A_IRQ, v); chk("R4 write0 keeps", v, 16'h0006);
        chk("R5 irq on", int'(irq), 1);
        wr_reg(A_IRQ, 16'h0006);
        rd_reg(A_IRQ, v); chk("R4 write1 clears", v, 16'h0002);
        chk("R5 irq off", int'(irq), 0);

        // R7 held on: no relaunch
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040); idle(4);
        rd_reg(A_CTRL, v); chk("R7 no second burst", v, 0);
        chk("R7 no second pulses", rises - r0, 0);

        // R8/R2 sweep of lengths
        for (int n = 1; n <= 16; n++) begin
            wr_reg(A_LEN, 16'(n << 8));
            pwr_state = 2'b00; idle(1);
            arm();
            r0 = rises;
            wr_reg(A_CTRL, 16'h0040);
            wait_done(cyc);
            chk("R8 sweep pulses", rises - r0, n);
            chk("R9 sweep ticks", cyc, 2 * n);
            chk("R5 irq after sweep", int'(irq), 1);
            wr_reg(A_IRQ, 16'h0006);
        end

        // R8 maximum length, slow ticks
        tick_per = 2;
        wr_reg(A_LEN, 16'hFF00);
        pwr_state = 2'b00; idle(1); arm();
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040);
        wait_done(cyc);
        chk("R8 len 255 pulses", rises - r0, 255);
        tick_per = 1;

        // R8 zero selects default
        wr_reg(A_LEN, 16'h0000);
        rd_reg(A_LEN, v); chk("R8 zero reads back", v, 0);
        pwr_state = 2'b00; idle(1); arm();
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040);
        wait_done(cyc);
        chk("R8 zero means 74", rises - r0, 74);

        // R6 writes during a burst
        wr_reg(A_LEN, 16'h0A00);
        pwr_state = 2'b00; idle(1); arm();
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040);
        idle(3);
        wr_reg(A_CTRL, 16'h0040);
        wr_reg(A_LEN, 16'h0300);
        rd_reg(A_LEN, v); chk("R6 len write ignored", v, 16'h0A00);
        wait_done(cyc);
        chk("R6 pulses unchanged", rises - r0, 10);

        // R7 off then on without ramping
        pwr_state = 2'b00; idle(2);
        pwr_state = 2'b11; idle(2);
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040); idle(3);
        rd_reg(A_CTRL, v); chk("R7 off-on no arm", v, 0);
        // R7 arming lost when power leaves on
        arm();
        pwr_state = 2'b10; idle(1); pwr_state = 2'b00; idle(1);
        wr_reg(A_CTRL, 16'h0040); idle(3);
        rd_reg(A_CTRL, v); chk("R7 arming dropped", v, 0);
        chk("R7 no pulses", rises - r0, 0);

        // R9 stalled tick
        wr_reg(A_IRQ, 16'h0004);
        arm();
        tick_per = 0;
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040);
        idle(20);
        chk("R9 no tick no pulse", rises - r0, 0);
        rd_reg(A_CTRL, v); chk("R9 still busy", v, 16'h0040);
        tick_per = 1;
        wait_done(cyc);
        chk("R9 resumes full", rises - r0, 10);

        // R10 reset aborts
        wr_reg(A_IRQ, 16'h0002);
        pwr_state = 2'b00; idle(1); arm();
        r0 = rises;
        wr_reg(A_CTRL, 16'h0040);
        idle(7);
        rst = 1; @(negedge clk); rst = 0;
        r0 = rises;
        rd_reg(A_CTRL, v); chk("R10 busy cleared", v, 0);
        rd_reg(A_IRQ, v);  chk("R10 irq reg cleared", v, 0);
        rd_reg(A_LEN, v);  chk("R10 len default", v, 16'h4A00);
        chk("R10 pad low", int'(card_clk), 0);
        wr_reg(A_CTRL, 16'h0040); idle(4);
        rd_reg(A_CTRL, v); chk("R10 arming cleared", v, 0);
        chk("R10 no pulses after", rises - r0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule